// File: doc/BRIEF.md
# Zero-Wait Local Bus Burst Slave

This block sits on the local side of a PCI-to-local-bus bridge and answers every cycle the bridge starts on a 32-bit multiplexed address/data bus. The bus clock runs at 40 MHz to line up with the converter timing, although the bus itself would allow 50 MHz. All local address and control lines of the bridge end here, and the block derives its whole operating state from them.

The controller has only two cycle states, idle and transfer. When the address strobe is seen low, the next clock edge puts the block straight into transfer, and the first data beat happens in that very cycle. There is no setup or wait state. The latched address is decoded into two windows. The acquisition FIFO window streams FIFO words back on DMA read bursts while the address stays fixed. The register window gives single-word access to a small bank of control and status words.

The five most significant data lines carry command codes. A code written to the status word starts, stops or flushes acquisition. Pending doorbell and mailbox interrupt requests are returned on the same five lines when the status word is read, and that read signals them to the bridge.

Top module: `lbus_burst_slave`

## Requirements
- R1: With the block idle, an address strobe (`as_n`) sampled low at a clock edge moves it into transfer at that edge. In the following cycle a beat completes (`rdy_n` low) if data is available; no setup cycle comes between them.
- R2: Address bits [15:12] equal to 1 select the FIFO window. Any other value selects the register window, where bits [3:2] choose one of four words.
- R3: In a FIFO read burst, each beat drives `fifo_data` onto `ld_o`, holds `ld_oe` high and pulses `fifo_rd`. The address is taken only once, so the values on `ld_in` during beats do not matter.
- R4: While `fifo_empty` is high during a FIFO read, `rdy_n` stays high and `fifo_rd` stays low. The beat completes once data is present again.
- R5: A beat that completes with `bl_n` low ends the transfer. In the next cycle the block is idle, `ld_oe` is low and `rdy_n` is high.
- R6: A write to the FIFO window completes with `rdy_n` low and is discarded. It produces no `fifo_rd` pulse and changes no register.
- R7: The direction and window are captured on the strobe cycle and held for the whole transfer. A change on `wr` during a read leaves `ld_oe` high and writes nothing.
- R8: Words 1 to 3 are read/write storage. Word 1 also drives `cfg_word`.
- R9: A write to word 0 decodes bits [31:27] as a command. 5'b00001 sets `acq_run`, 5'b00010 clears it, and 5'b00100 gives a one-cycle `fifo_flush` pulse in the cycle after the write. Any other code does nothing.
- R10: A `db_req` or `mb_req` pulse sets a pending flag. Reading word 0 returns the status layout: bit 31 set if any request is pending, bit 28 mailbox, bit 27 doorbell, bit 1 `acq_run`, bit 0 `fifo_empty`. The completed read clears both flags.
- R11: After reset the block is idle with `ld_oe` low, `rdy_n` high, `fifo_rd` low, `acq_run` low and `cfg_word` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| bl_n | input | 1 | Burst-last, active low |
| wr | input | 1 | Direction, 1 = write |
| ld_in | input | 32 | Multiplexed address/data from the bridge |
| ld_o | output | 32 | Read data toward the bridge |
| ld_oe | output | 1 | Data bus drive enable (low = high impedance) |
| rdy_n | output | 1 | Beat ready, active low |
| fifo_data | input | 32 | Head word of the acquisition FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_rd | output | 1 | FIFO pop strobe |
| db_req | input | 1 | Doorbell request pulse |
| mb_req | input | 1 | Mailbox request pulse |
| acq_run | output | 1 | Acquisition enable from command decode |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| cfg_word | output | 32 | Contents of register word 1 |

## Verification
The assertions assume that the FIFO shows its head word on `fifo_data` whenever `fifo_empty` is low, and that the bridge raises the strobe only while the block is idle. The stimulus therefore starts each cycle only after the previous transfer has ended. The bench FIFO model pops only on `fifo_rd` at a clock edge and forces empty only between beats. All inputs change at the falling edge, so every strobe, last and direction value is stable around the sampling edge.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int DATA_W = 32;
    localparam int CMD_W  = 5;
    localparam int IDX_W  = 2;
    localparam int NUM_WORDS = 1 << IDX_W;
    localparam int CMD_LSB = DATA_W - CMD_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } lbs_state_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE  = 5'b00000,
        CMD_RUN   = 5'b00001,
        CMD_HALT  = 5'b00010,
        CMD_FLUSH = 5'b00100
    } lbs_cmd_e;

    typedef struct packed {
        logic             wr;
        logic             fifo_win;
        logic [IDX_W-1:0] idx;
    } lbs_cycle_t;

    function automatic lbs_cycle_t make_cycle(input logic w, input logic is_fifo,
                                              input logic [IDX_W-1:0] word);
        lbs_cycle_t c;
        c.wr       = w;
        c.fifo_win = is_fifo;
        c.idx      = word;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic db, input logic mb,
                                                     input logic run, input logic empty);
        logic [DATA_W-1:0] s;
        s = '0;
        s[DATA_W-1]  = db | mb;
        s[CMD_LSB+1] = mb;
        s[CMD_LSB]   = db;
        s[1]         = run;
        s[0]         = empty;
        return s;
    endfunction

endpackage

// File: rtl/lbs_cycle_fsm.sv
module lbs_cycle_fsm
    import lbs_pkg::*;
#(
    parameter int PAGE_MSB  = 15,
    parameter int PAGE_LSB  = 12,
    parameter int FIFO_PAGE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              bl_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] addr,
    input  logic              fifo_empty,
    output lbs_cycle_t        cyc,
    output logic              xfer,
    output logic              beat,
    output logic              rdy_n,
    output logic              ld_oe
);
    localparam int PAGE_W = PAGE_MSB - PAGE_LSB + 1;

    lbs_state_e state;
    logic       hit_fifo;

    assign hit_fifo = (addr[PAGE_MSB:PAGE_LSB] == PAGE_W'(FIFO_PAGE));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cyc   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (!as_n) begin
                    state <= ST_XFER;
                    cyc   <= make_cycle(wr, hit_fifo, addr[IDX_W+1:2]);
                end
                ST_XFER: if (beat && !bl_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        xfer  = (state == ST_XFER);
        beat  = xfer && (cyc.wr || !cyc.fifo_win || !fifo_empty);
        rdy_n = !beat;
        ld_oe = xfer && !cyc.wr;
    end

    assert_strobe_starts_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !as_n) |=> (state == ST_XFER));
    assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (beat && !bl_n) |=> (state == ST_IDLE && !ld_oe && rdy_n));
    assert_cycle_held_R7: assert property (@(posedge clk) disable iff (rst)
        (xfer && $past(xfer)) |-> $stable(cyc));

endmodule

// File: rtl/lbs_fifo_port.sv
module lbs_fifo_port
    import lbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lbs_cycle_t        cyc,
    input  logic              beat,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [DATA_W-1:0] rd_word
);
    assign fifo_rd = beat && cyc.fifo_win && !cyc.wr;
    assign rd_word = fifo_data;

    assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !fifo_rd);
    assert_write_discard_R6: assert property (@(posedge clk) disable iff (rst)
        (beat && cyc.wr) |-> !fifo_rd);

endmodule

// File: rtl/lbs_reg_bank.sv
module lbs_reg_bank
    import lbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lbs_cycle_t        cyc,
    input  logic              beat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fifo_empty,
    input  logic              db_req,
    input  logic              mb_req,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cfg_word,
    output logic              acq_run,
    output logic              fifo_flush
);
    logic [DATA_W-1:0] words [NUM_WORDS];
    logic              wr_hit, rd_stat, db_pend, mb_pend;
    lbs_cmd_e          cmd;

    assign wr_hit  = beat && cyc.wr && !cyc.fifo_win;
    assign rd_stat = beat && !cyc.wr && !cyc.fifo_win && (cyc.idx == '0);
    assign cmd     = lbs_cmd_e'(wdata[DATA_W-1:CMD_LSB]);

    assign words[0] = status_word(db_pend, mb_pend, acq_run, fifo_empty);

    for (genvar g = 1; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) words[g] <= '0;
            else if (wr_hit && cyc.idx == IDX_W'(g)) words[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_run    <= 1'b0;
            fifo_flush <= 1'b0;
            db_pend    <= 1'b0;
            mb_pend    <= 1'b0;
        end else begin
            fifo_flush <= 1'b0;
            if (wr_hit && cyc.idx == '0) begin
                case (cmd)
                    CMD_RUN:   acq_run    <= 1'b1;
                    CMD_HALT:  acq_run    <= 1'b0;
                    CMD_FLUSH: fifo_flush <= 1'b1;
                    default:   ;
                endcase
            end
            db_pend <= db_req | (db_pend & !rd_stat);
            mb_pend <= mb_req | (mb_pend & !rd_stat);
        end
    end

    assign rdata    = words[cyc.idx];
    assign cfg_word = words[1];

    assert_db_latch_R10: assert property (@(posedge clk) disable iff (rst)
        db_req |=> db_pend);
    assert_run_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && cyc.idx == '0 && cmd == CMD_RUN) |=> acq_run);
    assert_fifo_win_untouched_R6: assert property (@(posedge clk) disable iff (rst)
        (beat && cyc.fifo_win) |=> $stable(cfg_word));

endmodule

// File: rtl/lbus_burst_slave.sv
module lbus_burst_slave
    import lbs_pkg::*;
#(
    parameter int PAGE_MSB  = 15,
    parameter int PAGE_LSB  = 12,
    parameter int FIFO_PAGE = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        as_n,
    input  logic        bl_n,
    input  logic        wr,
    input  logic [31:0] ld_in,
    output logic [31:0] ld_o,
    output logic        ld_oe,
    output logic        rdy_n,
    input  logic [31:0] fifo_data,
    input  logic        fifo_empty,
    output logic        fifo_rd,
    input  logic        db_req,
    input  logic        mb_req,
    output logic        acq_run,
    output logic        fifo_flush,
    output logic [31:0] cfg_word
);
    lbs_cycle_t        cyc;
    logic              xfer, beat;
    logic [DATA_W-1:0] fifo_word, reg_word;

    lbs_cycle_fsm #(
        .PAGE_MSB(PAGE_MSB), .PAGE_LSB(PAGE_LSB), .FIFO_PAGE(FIFO_PAGE)
    ) u_fsm (
        .clk(clk), .rst(rst), .as_n(as_n), .bl_n(bl_n), .wr(wr), .addr(ld_in),
        .fifo_empty(fifo_empty), .cyc(cyc), .xfer(xfer), .beat(beat),
        .rdy_n(rdy_n), .ld_oe(ld_oe)
    );

    lbs_fifo_port u_fifo (
        .clk(clk), .rst(rst), .cyc(cyc), .beat(beat), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd), .rd_word(fifo_word)
    );

    lbs_reg_bank u_regs (
        .clk(clk), .rst(rst), .cyc(cyc), .beat(beat), .wdata(ld_in),
        .fifo_empty(fifo_empty), .db_req(db_req), .mb_req(mb_req),
        .rdata(reg_word), .cfg_word(cfg_word), .acq_run(acq_run),
        .fifo_flush(fifo_flush)
    );

    assign ld_o = cyc.fifo_win ? fifo_word : reg_word;

    assert_oe_only_in_xfer_R5: assert property (@(posedge clk) disable iff (rst)
        ld_oe |-> xfer);

endmodule

// File: tb/sim_lbus_burst_slave.sv
module sim_lbus_burst_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1, bl_n = 1'b1, wr = 1'b0;
    logic [31:0] ld_in = '0;
    logic [31:0] ld_o, cfg_word;
    logic        ld_oe, rdy_n, fifo_rd, acq_run, fifo_flush;
    logic        db_req = 1'b0, mb_req = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] fmem [16];
    int          fhead = 0, ftail = 0;
    logic [31:0] fifo_data;
    logic        fifo_empty;
    int          nchk = 0, nerr = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    assign fifo_empty = (fhead == ftail) || stall;
    assign fifo_data  = fmem[fhead % 16];
    always @(posedge clk) if (fifo_rd) fhead <= fhead + 1;

    lbus_burst_slave u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .bl_n(bl_n), .wr(wr), .ld_in(ld_in),
        .ld_o(ld_o), .ld_oe(ld_oe), .rdy_n(rdy_n), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .db_req(db_req), .mb_req(mb_req),
        .acq_run(acq_run), .fifo_flush(fifo_flush), .cfg_word(cfg_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        fmem[ftail % 16] = w;
        ftail++;
    endtask

    task automatic bus_start(input logic [31:0] a, input logic w);
        @(negedge clk);
        as_n = 1'b0; ld_in = a; wr = w; bl_n = 1'b1;
        #1;
        @(posedge clk);
    endtask

    task automatic drive_beat(input logic [31:0] d, input logic w, input logic last);
        @(negedge clk);
        as_n = 1'b1; ld_in = d; wr = w; bl_n = !last;
        #1;
    endtask

    task automatic after_end(input string tag);
        @(negedge clk);
        bl_n = 1'b1;
        #1;
        chk({tag, " oe released"}, 32'(ld_oe), 32'd0);
        chk({tag, " rdy idle"}, 32'(rdy_n), 32'd1);
    endtask

    task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
        bus_start(a, 1'b1);
        drive_beat(d, 1'b1, 1'b1);
        @(posedge clk);
    endtask

    task automatic reg_read(input string tag, input logic [31:0] a, input logic [31:0] exp);
        bus_start(a, 1'b0);
        drive_beat(32'h0, 1'b0, 1'b1);
        chk({tag, " read rdy"}, 32'(rdy_n), 32'd0);
        chk({tag, " read data"}, ld_o, exp);
        @(posedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R11 rdy_n", 32'(rdy_n), 32'd1);
        chk("R11 ld_oe", 32'(ld_oe), 32'd0);
        chk("R11 fifo_rd", 32'(fifo_rd), 32'd0);
        chk("R11 acq_run", 32'(acq_run), 32'd0);
        chk("R11 cfg_word", cfg_word, 32'd0);
    endtask

    task automatic t_fifo_burst;
        for (int i = 0; i < 4; i++) push(32'hC0DE_0000 + 32'(i * 7));
        bus_start(32'h0000_1000, 1'b0);
        for (int i = 0; i < 4; i++) begin
            drive_beat(32'hDEAD_0000 ^ 32'(i), 1'b0, i == 3);
            chk("R1 R3 beat ready", 32'(rdy_n), 32'd0);
            chk("R3 burst data", ld_o, 32'hC0DE_0000 + 32'(i * 7));
            chk("R3 pop strobe", 32'(fifo_rd), 32'd1);
            chk("R3 drive enable", 32'(ld_oe), 32'd1);
            @(posedge clk);
        end
        after_end("R5 burst");
    endtask

    task automatic t_empty_stall;
        push(32'h1111_AAAA);
        push(32'h2222_BBBB);
        bus_start(32'h0000_1000, 1'b0);
        drive_beat(32'h0, 1'b0, 1'b0);
        chk("R4 first word", ld_o, 32'h1111_AAAA);
        @(posedge clk);
        @(negedge clk); stall = 1'b1; #1;
        chk("R4 stall rdy", 32'(rdy_n), 32'd1);
        chk("R4 stall no pop", 32'(fifo_rd), 32'd0);
        @(posedge clk);
        drive_beat(32'h0, 1'b0, 1'b1);
        stall = 1'b0; #1;
        chk("R4 resume rdy", 32'(rdy_n), 32'd0);
        chk("R4 resume word", ld_o, 32'h2222_BBBB);
        @(posedge clk);
        after_end("R4 end");
    endtask

    task automatic t_reg_rw;
        reg_write(32'h0000_0004, 32'hA5A5_1234);
        @(negedge clk); #1;
        chk("R8 cfg_word", cfg_word, 32'hA5A5_1234);
        reg_write(32'h0000_0008, 32'h1357_9BDF);
        reg_write(32'h0000_000C, 32'h0F0F_00FF);
        reg_read("R8 word2", 32'h0000_0008, 32'h1357_9BDF);
        reg_read("R8 word3", 32'h0000_000C, 32'h0F0F_00FF);
        reg_read("R8 word1", 32'h0000_0004, 32'hA5A5_1234);
    endtask

    task automatic t_decode;
        reg_read("R2 other page to regs", 32'h0000_2004, 32'hA5A5_1234);
    endtask

    task automatic t_fifo_write;
        int h0;
        h0 = fhead;
        bus_start(32'h0000_1004, 1'b1);
        drive_beat(32'hFFFF_0000, 1'b1, 1'b1);
        chk("R6 write accepted", 32'(rdy_n), 32'd0);
        chk("R6 no pop", 32'(fifo_rd), 32'd0);
        @(posedge clk);
        after_end("R6 end");
        chk("R6 fifo untouched", 32'(fhead), 32'(h0));
        chk("R6 cfg untouched", cfg_word, 32'hA5A5_1234);
    endtask

    task automatic t_dir_hold;
        bus_start(32'h0000_0008, 1'b0);
        drive_beat(32'hFFFF_FFFF, 1'b1, 1'b1);
        chk("R7 still reading", 32'(ld_oe), 32'd1);
        chk("R7 read data", ld_o, 32'h1357_9BDF);
        @(posedge clk);
        after_end("R7 end");
        reg_read("R7 word2 kept", 32'h0000_0008, 32'h1357_9BDF);
    endtask

    task automatic t_cmd;
        reg_write(32'h0, {5'b00001, 27'h0});
        @(negedge clk); #1;
        chk("R9 run set", 32'(acq_run), 32'd1);
        reg_write(32'h0, {5'b11000, 27'h7});
        @(negedge clk); #1;
        chk("R9 unknown code", 32'(acq_run), 32'd1);
        chk("R9 unknown no flush", 32'(fifo_flush), 32'd0);
        reg_write(32'h0, {5'b00010, 27'h0});
        @(negedge clk); #1;
        chk("R9 run cleared", 32'(acq_run), 32'd0);
        reg_write(32'h0, {5'b00100, 27'h0});
        @(negedge clk); #1;
        chk("R9 flush pulse", 32'(fifo_flush), 32'd1);
        @(negedge clk); #1;
        chk("R9 flush one cycle", 32'(fifo_flush), 32'd0);
    endtask

    task automatic t_irq;
        @(negedge clk); db_req = 1'b1;
        @(negedge clk); db_req = 1'b0;
        reg_read("R10 doorbell", 32'h0, 32'h8800_0001);
        reg_read("R10 cleared", 32'h0, 32'h0000_0001);
        @(negedge clk); mb_req = 1'b1;
        @(negedge clk); mb_req = 1'b0;
        reg_read("R10 mailbox", 32'h0, 32'h9000_0001);
        reg_read("R10 cleared again", 32'h0, 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_fifo_burst();
        t_empty_stall();
        t_reg_rw();
        t_decode();
        t_fifo_write();
        t_dir_hold();
        t_cmd();
        t_irq();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule